// File: doc/BRIEF.md
# Synchronous HDLC Bit-Stuffing Transmitter

This block turns byte frames from a frame buffer into a synchronous HDLC bit stream. It runs on the system clock. A single-cycle `bit_en` strobe marks each falling edge of the external transmit link clock, already brought into the system clock domain. On each strobe the block launches exactly one line bit on `txd`, which is registered and changes in the cycle after the strobe.

Each frame is sent as follows:
- an opening flag (0x7E);
- the frame body, least significant bit first;
- a 16-bit frame check sequence;
- a closing flag.

A zero is inserted after every run of five ones in the body and in the check sequence. Between frames, while clear-to-send is asserted, the line carries back-to-back flags.

The byte source presents frames on a valid/ready stream with a last-byte marker. Clear-to-send is active low. While it is deasserted the line is held high and nothing advances. If it stays deasserted for more than one bit time inside a frame, the frame is abandoned. The block then pulses `rewind` so that the source restarts the frame from its first byte. The replayed frame goes out after a full flag once clear-to-send returns. A frame that completes normally is acknowledged with a one-cycle `done` pulse.

Top module: `hdlc_sync_tx`

## Requirements
- R1: After reset, and before any strobe, `txd` is 1, `rts_n` is 1, and `in_ready`, `rewind` and `done` are all 0.
- R2: With `cts_n` low and no frame offered, the line carries continuous flags. A flag is the bit sequence 0,1,1,1,1,1,1,0 in time order (0x7E sent LSB first).
- R3: A frame goes out as an opening flag, then the body bytes in order with each byte sent LSB first, then the check sequence, then a closing flag. The body starts only at a flag boundary.
- R4: Between the flags, after every five consecutive 1 bits (body or check sequence), a 0 is inserted. No six consecutive ones ever appear between flags.
- R5: The check sequence is the CRC-16 with reflected polynomial 0x8408, computed bitwise over the body bits as sent. The register is preset to 0xFFFF and the result is ones-complemented. The low byte is sent first, each byte LSB first.
- R6: On a strobe with `cts_n` high, the bit launched is 1 and the frame does not advance. A single such strobe inside a frame is followed by normal continuation, with no rewind.
- R7: Two consecutive strobes with `cts_n` high inside a frame (body or check sequence) abort it. `rewind` pulses once and the frame is re-sent in full from its first byte after a complete flag.
- R8: `done` pulses for exactly one cycle once per frame completed normally. It never pulses for an aborted attempt, and never in the same cycle as `rewind`.
- R9: `rts_n` is low while `in_valid` is high or a frame is in progress, and high when neither holds.
- R10: `in_ready` is high only in a strobe cycle with `cts_n` low. A byte transfers when `in_valid` and `in_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | One-cycle strobe per transmit link clock falling edge |
| cts_n | input | 1 | Clear-to-send, active low |
| in_valid | input | 1 | Source has a byte available |
| in_data | input | 8 | Byte from the source |
| in_last | input | 1 | Byte is the last of its frame |
| in_ready | output | 1 | Block takes the byte this cycle |
| rewind | output | 1 | One-cycle request to restart the current frame from its first byte |
| done | output | 1 | One-cycle acknowledge of a completed frame |
| rts_n | output | 1 | Request-to-send, active low |
| txd | output | 1 | Serial line data |

## Verification
The checks assume three things about the inputs:
- `bit_en` is a single-cycle strobe.
- The source keeps `in_valid`, `in_data` and `in_last` steady between strobes.
- Once a frame has started, the source can always supply the next byte at a byte boundary, since it reads from a frame buffer.

The stimulus keeps within these assumptions. It strobes every other cycle, and changes source and clear-to-send inputs only on the falling clock edge. It presents a whole stored frame and restarts it from byte zero whenever `rewind` is seen. Clear-to-send gaps are placed only after the second byte has been taken, so a gap always lands inside a frame body or its check sequence.

// File: rtl/hdlc_sync_tx_pkg.sv
package hdlc_sync_tx_pkg;
    localparam int BYTE_W = 8;
    localparam int FCS_W  = 16;
    localparam logic [BYTE_W-1:0] FLAG_PAT   = 8'h7E;
    localparam logic [FCS_W-1:0]  CRC_POLY_R = 16'h8408;
    localparam logic [FCS_W-1:0]  CRC_PRESET = 16'hFFFF;

    typedef enum logic [1:0] {
        ST_FLAG = 2'd0,
        ST_BODY = 2'd1,
        ST_FCS  = 2'd2
    } tx_st_e;
endpackage

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs
    import hdlc_sync_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [FCS_W-1:0] crc_q
);
    logic [FCS_W-1:0] crc_d;
    logic             fb;

    always_comb begin
        fb    = crc_q[0] ^ bit_in;
        crc_d = crc_q;
        if (init) begin
            crc_d = CRC_PRESET;
        end else if (shift_en) begin
            crc_d = (crc_q >> 1) ^ (fb ? CRC_POLY_R : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= CRC_PRESET;
        else        crc_q <= crc_d;
    end

    // R5
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !shift_en) |=> $stable(crc_q));
endmodule

// File: rtl/hdlc_tx_gap.sv
module hdlc_tx_gap #(
    parameter int GAP_LIMIT = 1,
    localparam int CW = $clog2(GAP_LIMIT + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic cts_n,
    output logic over
);
    logic [CW-1:0] gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (bit_en) begin
            if (!cts_n)                           gap_d = '0;
            else if (gap_q != CW'(GAP_LIMIT + 1)) gap_d = gap_q + 1'b1;
        end
        over = bit_en && cts_n && (gap_q >= CW'(GAP_LIMIT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gap_q <= '0;
        else        gap_q <= gap_d;
    end

    // R6
    gap_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !cts_n) |=> !over);
endmodule

// File: rtl/hdlc_sync_tx.sv
module hdlc_sync_tx
    import hdlc_sync_tx_pkg::*;
#(
    parameter int RUN_LEN   = 5,
    parameter int GAP_LIMIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              cts_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              rewind,
    output logic              done,
    output logic              rts_n,
    output logic              txd
);
    localparam int CNT_W  = $clog2(FCS_W + 1);
    localparam int ONES_W = $clog2(RUN_LEN + 1);

    typedef struct packed {
        tx_st_e            st;
        logic [CNT_W-1:0]  cnt;
        logic [ONES_W-1:0] ones;
        logic [BYTE_W-1:0] sh;
        logic [FCS_W-1:0]  fsh;
        logic              last;
        logic              txd;
        logic              rew;
        logic              done;
    } tx_reg_t;

    tx_reg_t          q, d;
    logic             crc_init, crc_shift, crc_bit, over;
    logic [FCS_W-1:0] crc_q, fcs_w;

    hdlc_tx_fcs u_fcs (
        .clk(clk), .rst_n(rst_n), .init(crc_init), .shift_en(crc_shift),
        .bit_in(crc_bit), .crc_q(crc_q)
    );

    hdlc_tx_gap #(.GAP_LIMIT(GAP_LIMIT)) u_gap (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cts_n(cts_n), .over(over)
    );

    always_comb begin
        d         = q;
        d.rew     = 1'b0;
        d.done    = 1'b0;
        in_ready  = 1'b0;
        crc_init  = 1'b0;
        crc_shift = 1'b0;
        crc_bit   = 1'b0;
        fcs_w     = (q.cnt == '0) ? ~crc_q : q.fsh;
        if (bit_en) begin
            if (cts_n) begin
                d.txd = 1'b1;
                if (over && q.st != ST_FLAG) begin
                    d.st   = ST_FLAG;
                    d.cnt  = '0;
                    d.ones = '0;
                    d.rew  = 1'b1;
                end
            end else begin
                unique case (q.st)
                    ST_FLAG: begin
                        d.txd = FLAG_PAT[q.cnt[2:0]];
                        if (q.cnt == CNT_W'(BYTE_W - 1)) begin
                            d.cnt  = '0;
                            d.ones = '0;
                            if (in_valid) begin
                                in_ready = 1'b1;
                                crc_init = 1'b1;
                                d.sh     = in_data;
                                d.last   = in_last;
                                d.st     = ST_BODY;
                            end
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                    ST_BODY: begin
                        if (q.ones == ONES_W'(RUN_LEN)) begin
                            d.txd  = 1'b0;
                            d.ones = '0;
                        end else begin
                            d.txd     = q.sh[0];
                            d.sh      = q.sh >> 1;
                            crc_shift = 1'b1;
                            crc_bit   = q.sh[0];
                            d.ones    = q.sh[0] ? q.ones + 1'b1 : '0;
                            if (q.cnt == CNT_W'(BYTE_W - 1)) begin
                                d.cnt = '0;
                                if (q.last) begin
                                    d.st = ST_FCS;
                                end else begin
                                    in_ready = 1'b1;
                                    d.sh     = in_data;
                                    d.last   = in_last;
                                end
                            end else begin
                                d.cnt = q.cnt + 1'b1;
                            end
                        end
                    end
                    ST_FCS: begin
                        if (q.ones == ONES_W'(RUN_LEN)) begin
                            d.txd  = 1'b0;
                            d.ones = '0;
                        end else if (q.cnt == CNT_W'(FCS_W)) begin
                            d.txd  = FLAG_PAT[0];
                            d.st   = ST_FLAG;
                            d.cnt  = CNT_W'(1);
                            d.ones = '0;
                            d.done = 1'b1;
                        end else begin
                            d.txd  = fcs_w[0];
                            d.fsh  = fcs_w >> 1;
                            d.ones = fcs_w[0] ? q.ones + 1'b1 : '0;
                            d.cnt  = q.cnt + 1'b1;
                        end
                    end
                    default: d.st = ST_FLAG;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_FLAG;
            q.txd <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign txd    = q.txd;
    assign rewind = q.rew;
    assign done   = q.done;
    assign rts_n  = !(in_valid || q.st != ST_FLAG);

    // R6
    hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && cts_n) |=> txd);
    // R4
    stuff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !cts_n && q.st != ST_FLAG && q.ones == ONES_W'(RUN_LEN)) |=> !txd);
    // R8
    rew_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rewind && done));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    rewind_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |-> (q.st == ST_FLAG && q.cnt == '0));
endmodule

// File: tb/hdlc_sync_tx_tb.sv
module hdlc_sync_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       cts_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready, rewind, done, rts_n, txd;

    always #5 clk = ~clk;

    hdlc_sync_tx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cts_n(cts_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .rewind(rewind), .done(done),
        .rts_n(rts_n), .txd(txd)
    );

    int checks = 0, failures = 0;
    int cyc = 0;
    bit wd = 0;
    logic [7:0] fr [0:63];
    int flen = 0, idx = 0;
    bit active = 0;
    bit tick_prev = 0, cts_prev = 0, take_prev = 0;
    int gap_len = 0, gap_left = 0;
    bit gap_arm = 0;
    int rewinds = 0, dones = 0, flags = 0, frames_seen = 0;
    int r10_viol = 0, r6_viol = 0, r9_viol = 0;
    bit raw [0:4095];
    int rn = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fcs_of();
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < flen; k++) begin
            for (int i = 0; i < 8; i++) begin
                logic fb = c[0] ^ fr[k][i];
                c = (c >> 1) ^ (fb ? 16'h8408 : 16'h0000);
            end
        end
        return ~c;
    endfunction

    task automatic body_done();
        bit bits [0:4095];
        int nb = 0, ones = 0, mism = -1;
        bit err = 0;
        logic [15:0] f;
        logic [7:0] expb, gotb;
        for (int i = 0; i < rn - 8; i++) begin
            if (ones == 5) begin
                if (raw[i]) err = 1;
                ones = 0;
            end else begin
                bits[nb] = raw[i];
                nb++;
                ones = raw[i] ? ones + 1 : 0;
            end
        end
        if (nb == 0) return;
        frames_seen++;
        // R4: no six ones between flags
        check(!err, "R4 stuffing", err, 0);
        f = fcs_of();
        check(nb == (flen + 2) * 8, "R3 length bits", nb, (flen + 2) * 8);
        if (nb == (flen + 2) * 8) begin
            for (int k = 0; k < flen + 2; k++) begin
                for (int i = 0; i < 8; i++) gotb[i] = bits[k * 8 + i];
                expb = (k < flen) ? fr[k] : ((k == flen) ? f[7:0] : f[15:8]);
                if (gotb !== expb && mism < 0) begin
                    mism = k;
                    // R3 R5: body bytes and check sequence
                    check(0, "R3/R5 byte", gotb, expb);
                end
            end
            if (mism < 0) check(1, "R5", 0, 0);
        end
    endtask

    task automatic rx_bit(input bit b);
        if (rn < 4096) begin
            raw[rn] = b;
            rn++;
        end
        if (rn >= 8 && raw[rn-8] == 0 && raw[rn-7] && raw[rn-6] && raw[rn-5] &&
            raw[rn-4] && raw[rn-3] && raw[rn-2] && raw[rn-1] == 0) begin
            flags++;
            body_done();
            rn = 0;
        end
    endtask

    task automatic cycle();
        @(negedge clk);
        if (tick_prev) begin
            if (!cts_prev) rx_bit(txd);
            else if (txd !== 1'b1) r6_viol++;
        end
        if (take_prev) idx++;
        if (rewind) begin
            rewinds++;
            idx = 0;
            rn = 0;
        end
        if (done) dones++;
        bit_en = (cyc % 2 == 0);
        if (bit_en) begin
            if (gap_arm && idx >= 2) begin
                gap_left = gap_len;
                gap_arm = 0;
            end
            if (gap_left > 0) begin
                cts_n = 1'b1;
                gap_left--;
            end else begin
                cts_n = 1'b0;
            end
        end
        in_valid = active && (idx < flen);
        in_data  = fr[idx];
        in_last  = (idx == flen - 1);
        #1;
        take_prev = in_ready && in_valid;
        if (in_ready && !(bit_en && !cts_n)) r10_viol++;
        if (in_valid && rts_n) r9_viol++;
        tick_prev = bit_en;
        cts_prev  = cts_n;
        cyc++;
        if (cyc > 150000) wd = 1;
    endtask

    task automatic run_frame(input int glen);
        int fs0 = frames_seen, d0 = dones, r0 = rewinds, t = 0;
        bit mid_done = 0;
        idx = 0;
        active = 1;
        gap_len = glen;
        gap_arm = (glen > 0);
        while (frames_seen == fs0 && t < 4000 && !wd) begin
            cycle();
            t++;
            if (!mid_done && idx == flen && dones == d0) begin
                mid_done = 1;
                // R9: frame still in progress after last byte taken
                check(rts_n == 1'b0, "R9 in-progress", rts_n, 0);
            end
        end
        active = 0;
        check(frames_seen == fs0 + 1, "R3 frame decoded", frames_seen - fs0, 1);
        for (int i = 0; i < 4; i++) cycle();
        // R8: one acknowledge per completed frame
        check(dones - d0 == 1, "R8 done count", dones - d0, 1);
        // R6 R7: rewind only for gaps over one bit
        check(rewinds - r0 == ((glen >= 2) ? 1 : 0), "R7 rewind count",
              rewinds - r0, (glen >= 2) ? 1 : 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(txd == 1'b1 && rts_n == 1'b1 && !in_ready && !rewind && !done,
              "R1 reset", {txd, rts_n, in_ready, rewind, done}, 5'b11000);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd == 1'b1 && rts_n == 1'b1, "R1 after release", {txd, rts_n}, 2'b11);

        // R2: idle flags
        for (int i = 0; i < 80; i++) cycle();
        check(flags >= 4, "R2 idle flags", flags, 4);
        check(frames_seen == 0, "R2 no frame", frames_seen, 0);
        check(rts_n == 1'b1, "R9 idle", rts_n, 1);

        // sweep of every single-byte frame value
        flen = 1;
        for (int v = 0; v < 256 && !wd; v++) begin
            fr[0] = v[7:0];
            run_frame(0);
        end

        // multi-byte patterns: heavy stuffing, flag bytes, zeros, ramp
        flen = 6;
        for (int k = 0; k < 6; k++) fr[k] = 8'hFF;
        run_frame(0);
        for (int k = 0; k < 6; k++) fr[k] = 8'h7E;
        run_frame(0);
        for (int k = 0; k < 6; k++) fr[k] = 8'h00;
        run_frame(0);
        flen = 16;
        for (int k = 0; k < 16; k++) fr[k] = 8'(k * 37 + 5);
        run_frame(0);

        // R6: one-bit gap continues, R7: longer gaps abort and replay
        flen = 8;
        for (int k = 0; k < 8; k++) fr[k] = 8'(8'hF0 ^ (k * 17));
        run_frame(1);
        run_frame(2);
        run_frame(5);
        for (int k = 0; k < 8; k++) fr[k] = 8'hFF;
        run_frame(3);

        check(r6_viol == 0, "R6 held high", r6_viol, 0);
        check(r10_viol == 0, "R10 ready gating", r10_viol, 0);
        check(r9_viol == 0, "R9 request", r9_viol, 0);
        for (int i = 0; i < 20; i++) cycle();
        check(rts_n == 1'b1, "R9 released", rts_n, 1);
        if (wd) check(0, "watchdog", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule